// File: doc/BRIEF.md
# Masked Control/Status Register Write Unit

This block holds the supervisor and machine control/status registers of a processor core and enforces the write rules of each one. A single write port (enable, 5-bit address, 64-bit data) changes at most one architectural view per cycle. Several addresses are partial views of shared storage. The supervisor status view sits over machine status. The supervisor pending and enable views sit over the machine pending and enable registers. The combined floating-point control view sits over the flag and rounding-mode registers. The unit keeps all of these views consistent.

Legality filtering is applied field by field. The unit recomputes the summary dirty bit after every status change and raises a one-cycle translation-flush pulse when a status write touches any field that affects address translation. Three interrupt-pending bits are driven out as level signals. A combinational read port returns any view. Timer addresses accept writes and discard them. Unknown addresses are ignored and flagged.

Address map (5-bit): 0 flags, 1 rounding mode, 2 combined FP control, 3 machine status, 4 supervisor status, 5 machine pending, 6 machine enable, 7 supervisor pending, 8 supervisor enable, 9 supervisor exception PC, 10 supervisor trap vector, 11 page-table base, 12 supervisor scratch, 13 machine exception PC, 14 machine scratch, 15 machine cause, 16 machine bad address, 17 to 20 timer registers, 21 to 31 unimplemented.

Top module: `csr_mask_unit`

## Requirements
- R1: A write to address 0, 1 or 2 sets machine status bits 13:12 (FP state) to 2'b11 and sets bit 63 (summary dirty). The flush pulse stays low.
- R2: Address 0 keeps data bits 4:0 and address 1 keeps data bits 2:0. A write to address 2 loads flags from bits 4:0 and rounding mode from bits 7:5. Address 2 reads back {mode, flags} in bits 7:0, and all wider bits read as zero.
- R3: A write to address 3 always updates bit 0 (IE), bit 3 (IE1), bit 6 (IE2), bit 16 (MPRV) and bits 13:12 (FP state). Bits 15:14 (extension state) are read-only and reset to 0. Reset value of machine status is 64'h6.
- R4: Privilege fields at bits 2:1, 5:4 and 8:7 each take the written value only if it is not 2. An illegal value leaves the old field value in place.
- R5: The VM field at bits 21:17 takes the written value only if it is 0 or 9. Any other value leaves the field unchanged.
- R6: After every status update, bit 63 equals 1 exactly when bits 13:12 are 2'b11 or bits 15:14 are 2'b11.
- R7: tlb_flush is high for exactly the one cycle after a write to address 3 or 4 whose written value differs from the stored value in bits 21:17, 2:1, 5:4 or 16. The comparison uses the written value, before legality filtering.
- R8: Address 4 reads machine status masked to bits 0, 3, 4, 12 to 16 and 63. A write to address 4 sets IE from data bit 0, IE1 from bit 3, bits 5:4 from {0, data bit 4}, FP state from bits 13:12 and MPRV from bit 16. The result then goes through the machine-status rules.
- R9: Machine pending (address 5) stores only bits 1 (SSIP), 3 (MSIP) and 5 (STIP). Machine enable (address 6) stores only bits 1, 3, 5 and 7 (MTIP).
- R10: A write to address 7 changes only bit 1 of machine pending. A write to address 8 changes only bits 1, 5 and 9 of machine enable. Address 7 reads pending bits 1 and 5, and address 8 reads enable bits 1, 5 and 9.
- R11: irq_ssip, irq_msip and irq_stip equal machine-pending bits 1, 3 and 5, starting from the cycle after the write.
- R12: The trap vector (address 10) clears data bits 1:0, and the page-table base (address 11) clears bits 11:0. Addresses 9 and 12 to 16 store the data unmodified. All of these reset to 0.
- R13: Writes to addresses 17 to 20 change no state, raise no flag and read back as 0.
- R14: A write to addresses 21 to 31 changes no state and raises illegal_wr for exactly the following cycle. These addresses read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 64 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 64 | Combinational read data |
| tlb_flush | output | 1 | One-cycle translation flush pulse |
| illegal_wr | output | 1 | One-cycle unknown-address flag |
| irq_ssip | output | 1 | Supervisor software interrupt pending level |
| irq_stip | output | 1 | Supervisor timer interrupt pending level |
| irq_msip | output | 1 | Machine software interrupt pending level |

## Verification
A single status write can do two things in the same cycle: it can leave a field unchanged because the written value is illegal, and it can still fire the flush pulse because the written value differs from the stored one. The privilege sweep and the VM sweep push every encoding through address 3, including the reserved ones. For each write, the bench checks the read-back field against the legality rule and checks the flush line against a plain XOR of the written and previous values. A second overlap arises on supervisor-status writes, which change the previous-privilege field, the FP state and the summary dirty bit together. The sstatus sweep checks the flush pulse and the recomputed bit 63 on both views at once.

// File: rtl/csr_mw_pkg.sv
package csr_mw_pkg;
  localparam int XLEN = 64;
  localparam int AW   = 5;

  typedef logic [XLEN-1:0] word_t;
  typedef logic [AW-1:0]   addr_t;

  localparam addr_t A_FFLAGS   = 5'd0;
  localparam addr_t A_FRM      = 5'd1;
  localparam addr_t A_FCSR     = 5'd2;
  localparam addr_t A_MSTAT    = 5'd3;
  localparam addr_t A_SSTAT    = 5'd4;
  localparam addr_t A_MIP      = 5'd5;
  localparam addr_t A_MIE      = 5'd6;
  localparam addr_t A_SIP      = 5'd7;
  localparam addr_t A_SIE      = 5'd8;
  localparam addr_t A_STORE0   = 5'd9;
  localparam addr_t A_TMR0     = 5'd17;
  localparam addr_t A_TMR_LAST = 5'd20;

  localparam int NSTORE   = 8;
  localparam int S_STVEC  = 1;
  localparam int S_PTBASE = 2;

  localparam int FF_W  = 5;
  localparam int RM_W  = 3;
  localparam int PRV_W = 2;
  localparam int ST_W  = 2;
  localparam int VM_W  = 5;

  localparam int B_IE     = 0;
  localparam int B_PRV    = 1;
  localparam int B_IE1    = 3;
  localparam int B_PRV1   = 4;
  localparam int B_IE2    = 6;
  localparam int B_PRV2   = 7;
  localparam int B_FS     = 12;
  localparam int B_XS     = 14;
  localparam int B_MPRV   = 16;
  localparam int B_VM     = 17;
  localparam int B_SD     = XLEN - 1;

  localparam int I_SSIP = 1;
  localparam int I_MSIP = 3;
  localparam int I_STIP = 5;
  localparam int I_MTIP = 7;
  localparam int I_SXIP = 9;

  localparam logic [PRV_W-1:0] PRV_RESERVED = 2'd2;
  localparam logic [PRV_W-1:0] PRV_TOP      = 2'd3;

  function automatic word_t fld(input int lo, input int w);
    return ((word_t'(1) << w) - word_t'(1)) << lo;
  endfunction

  localparam word_t M_ALWAYS = fld(B_IE, 1) | fld(B_IE1, 1) | fld(B_IE2, 1) |
                               fld(B_MPRV, 1) | fld(B_FS, ST_W);
  localparam word_t M_FLUSH  = fld(B_VM, VM_W) | fld(B_PRV, PRV_W) |
                               fld(B_PRV1, PRV_W) | fld(B_MPRV, 1);
  localparam word_t M_SVIEW  = fld(B_IE, 1) | fld(B_IE1, 1) | fld(B_PRV1, 1) |
                               fld(B_FS, ST_W) | fld(B_XS, ST_W) |
                               fld(B_MPRV, 1) | fld(B_SD, 1);

  localparam word_t M_MIP_WR = fld(I_SSIP, 1) | fld(I_MSIP, 1) | fld(I_STIP, 1);
  localparam word_t M_MIE_WR = M_MIP_WR | fld(I_MTIP, 1);
  localparam word_t M_SIP_WR = fld(I_SSIP, 1);
  localparam word_t M_SIP_RD = fld(I_SSIP, 1) | fld(I_STIP, 1);
  localparam word_t M_SIE_WR = fld(I_SSIP, 1) | fld(I_STIP, 1) | fld(I_SXIP, 1);

  function automatic logic addr_known(input addr_t a);
    return a <= A_TMR_LAST;
  endfunction
endpackage

// File: rtl/csr_fp_regs.sv
module csr_fp_regs
  import csr_mw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  addr_t           wr_addr,
  input  logic [7:0]      wr_low,
  output logic [FF_W-1:0] fflags,
  output logic [RM_W-1:0] frm,
  output logic            fp_touch
);
  logic [FF_W-1:0] ff_q, ff_d;
  logic [RM_W-1:0] rm_q, rm_d;
  logic            ff_en, rm_en;

  always_comb begin
    ff_d  = ff_q;
    rm_d  = rm_q;
    ff_en = 1'b0;
    rm_en = 1'b0;
    if (wr_en) begin
      unique case (wr_addr)
        A_FFLAGS: begin ff_d = wr_low[FF_W-1:0]; ff_en = 1'b1; end
        A_FRM:    begin rm_d = wr_low[RM_W-1:0]; rm_en = 1'b1; end
        A_FCSR: begin
          ff_d  = wr_low[FF_W-1:0];
          rm_d  = wr_low[FF_W +: RM_W];
          ff_en = 1'b1;
          rm_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q <= '0;
      rm_q <= '0;
    end else begin
      if (ff_en) ff_q <= ff_d;
      if (rm_en) rm_q <= rm_d;
    end
  end

  assign fflags   = ff_q;
  assign frm      = rm_q;
  assign fp_touch = ff_en | rm_en;

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_FRM) |=> $stable(ff_q)); // R2
endmodule

// File: rtl/csr_status_path.sv
module csr_status_path
  import csr_mw_pkg::*;
#(
  parameter logic [VM_W-1:0] VM_PAGED = 5'd9
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  addr_t wr_addr,
  input  word_t wr_data,
  input  logic  fp_touch,
  output word_t mstatus,
  output logic  flush
);
  word_t st_q, st_d, src, wmask, merged;
  logic  take, st_en, flush_d, flush_q;

  function automatic logic prv_ok(input logic [PRV_W-1:0] p);
    return p != PRV_RESERVED;
  endfunction

  function automatic logic vm_ok(input logic [VM_W-1:0] v);
    return (v == '0) || (v == VM_PAGED);
  endfunction

  always_comb begin
    take = 1'b0;
    src  = wr_data;
    if (wr_en && wr_addr == A_MSTAT) begin
      take = 1'b1;
    end else if (wr_en && wr_addr == A_SSTAT) begin
      take                 = 1'b1;
      src                  = st_q;
      src[B_IE]            = wr_data[B_IE];
      src[B_IE1]           = wr_data[B_IE1];
      src[B_PRV1 +: PRV_W] = {1'b0, wr_data[B_PRV1]};
      src[B_FS +: ST_W]    = wr_data[B_FS +: ST_W];
      src[B_MPRV]          = wr_data[B_MPRV];
    end
  end

  always_comb begin
    wmask = M_ALWAYS;
    if (vm_ok(src[B_VM +: VM_W]))      wmask = wmask | fld(B_VM, VM_W);
    if (prv_ok(src[B_PRV +: PRV_W]))   wmask = wmask | fld(B_PRV, PRV_W);
    if (prv_ok(src[B_PRV1 +: PRV_W]))  wmask = wmask | fld(B_PRV1, PRV_W);
    if (prv_ok(src[B_PRV2 +: PRV_W]))  wmask = wmask | fld(B_PRV2, PRV_W);
    merged       = (st_q & ~wmask) | (src & wmask);
    merged[B_SD] = (&merged[B_FS +: ST_W]) | (&merged[B_XS +: ST_W]);
  end

  always_comb begin
    st_d    = st_q;
    flush_d = 1'b0;
    st_en   = 1'b0;
    if (take) begin
      st_d    = merged;
      st_en   = 1'b1;
      flush_d = |((src ^ st_q) & M_FLUSH);
    end else if (fp_touch) begin
      st_d[B_FS +: ST_W] = '1;
      st_d[B_SD]         = 1'b1;
      st_en              = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= word_t'(PRV_TOP) << B_PRV;
      flush_q <= 1'b0;
    end else begin
      if (st_en) st_q <= st_d;
      flush_q <= flush_d;
    end
  end

  assign mstatus = st_q;
  assign flush   = flush_q;

  AST_PRV_NEVER_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[B_PRV +: PRV_W] != PRV_RESERVED); // R4
  AST_SD_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[B_SD] == ((&st_q[B_FS +: ST_W]) | (&st_q[B_XS +: ST_W]))); // R6
  AST_XS_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(st_q[B_XS +: ST_W])); // R3
  AST_FLUSH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> ($past(wr_en) && ($past(wr_addr) == A_MSTAT || $past(wr_addr) == A_SSTAT))); // R7
  AST_FP_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    fp_touch |=> (&st_q[B_FS +: ST_W]) && st_q[B_SD]); // R1
endmodule

// File: rtl/csr_irq_path.sv
module csr_irq_path
  import csr_mw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  addr_t wr_addr,
  input  word_t wr_data,
  output word_t mip,
  output word_t mie,
  output logic  irq_ssip,
  output logic  irq_stip,
  output logic  irq_msip
);
  word_t mip_q, mip_d, mie_q, mie_d, mip_m, mie_m;
  logic  mip_en, mie_en;

  always_comb begin
    mip_m  = '0;
    mie_m  = '0;
    mip_en = 1'b0;
    mie_en = 1'b0;
    if (wr_en) begin
      unique case (wr_addr)
        A_MIP: begin mip_m = M_MIP_WR; mip_en = 1'b1; end
        A_SIP: begin mip_m = M_SIP_WR; mip_en = 1'b1; end
        A_MIE: begin mie_m = M_MIE_WR; mie_en = 1'b1; end
        A_SIE: begin mie_m = M_SIE_WR; mie_en = 1'b1; end
        default: ;
      endcase
    end
    mip_d = (mip_q & ~mip_m) | (wr_data & mip_m);
    mie_d = (mie_q & ~mie_m) | (wr_data & mie_m);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mip_q <= '0;
      mie_q <= '0;
    end else begin
      if (mip_en) mip_q <= mip_d;
      if (mie_en) mie_q <= mie_d;
    end
  end

  assign mip      = mip_q;
  assign mie      = mie_q;
  assign irq_ssip = mip_q[I_SSIP];
  assign irq_stip = mip_q[I_STIP];
  assign irq_msip = mip_q[I_MSIP];

  AST_MTIP_NOT_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mip_q[I_MTIP]); // R9
  AST_SIP_KEEPS_MSIP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_SIP) |=> $stable(mip_q[I_MSIP]) && $stable(mip_q[I_STIP])); // R10
  AST_SIE_KEEPS_MSIE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_SIE) |=> $stable(mie_q[I_MSIP]) && $stable(mie_q[I_MTIP])); // R10
endmodule

// File: rtl/csr_store_regs.sv
module csr_store_regs
  import csr_mw_pkg::*;
#(
  parameter int PG_SHIFT = 12
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  addr_t wr_addr,
  input  word_t wr_data,
  output word_t regs_o [NSTORE]
);
  function automatic word_t keep_mask(input int idx);
    if (idx == S_STVEC)  return ~word_t'(3);
    if (idx == S_PTBASE) return ~((word_t'(1) << PG_SHIFT) - word_t'(1));
    return '1;
  endfunction

  for (genvar g = 0; g < NSTORE; g++) begin : g_reg
    localparam addr_t MY_ADDR = A_STORE0 + addr_t'(g);
    localparam word_t MY_MASK = keep_mask(g);
    word_t q, d;
    logic  en;

    always_comb begin
      en = wr_en && (wr_addr == MY_ADDR);
      d  = wr_data & MY_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign regs_o[g] = q;
  end

  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    regs_o[S_STVEC][1:0] == 2'b00); // R12
  AST_PTB_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    regs_o[S_PTBASE][PG_SHIFT-1:0] == '0); // R12
endmodule

// File: rtl/csr_mask_unit.sv
module csr_mask_unit
  import csr_mw_pkg::*;
#(
  parameter logic [VM_W-1:0] VM_PAGED = 5'd9,
  parameter int              PG_SHIFT = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [4:0]   wr_addr,
  input  logic [63:0]  wr_data,
  input  logic [4:0]   rd_addr,
  output logic [63:0]  rd_data,
  output logic         tlb_flush,
  output logic         illegal_wr,
  output logic         irq_ssip,
  output logic         irq_stip,
  output logic         irq_msip
);
  logic [FF_W-1:0] fflags;
  logic [RM_W-1:0] frm;
  logic            fp_touch;
  word_t           mstatus, mip, mie;
  word_t           store_q [NSTORE];
  logic            ill_d, ill_q;

  csr_fp_regs u_fp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_low   (wr_data[7:0]),
    .fflags   (fflags),
    .frm      (frm),
    .fp_touch (fp_touch)
  );

  csr_status_path #(.VM_PAGED(VM_PAGED)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .fp_touch (fp_touch),
    .mstatus  (mstatus),
    .flush    (tlb_flush)
  );

  csr_irq_path u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mip      (mip),
    .mie      (mie),
    .irq_ssip (irq_ssip),
    .irq_stip (irq_stip),
    .irq_msip (irq_msip)
  );

  csr_store_regs #(.PG_SHIFT(PG_SHIFT)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .regs_o  (store_q)
  );

  always_comb ill_d = wr_en && !addr_known(wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ill_q <= 1'b0;
    else        ill_q <= ill_d;
  end

  assign illegal_wr = ill_q;

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_FFLAGS: rd_data = word_t'(fflags);
      A_FRM:    rd_data = word_t'(frm);
      A_FCSR:   rd_data = word_t'({frm, fflags});
      A_MSTAT:  rd_data = mstatus;
      A_SSTAT:  rd_data = mstatus & M_SVIEW;
      A_MIP:    rd_data = mip;
      A_MIE:    rd_data = mie;
      A_SIP:    rd_data = mip & M_SIP_RD;
      A_SIE:    rd_data = mie & M_SIE_WR;
      default: begin
        for (int i = 0; i < NSTORE; i++) begin
          if (rd_addr == A_STORE0 + addr_t'(i)) rd_data = store_q[i];
        end
      end
    endcase
  end

  AST_ILL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_wr |-> ($past(wr_en) && $past(wr_addr) > A_TMR_LAST)); // R14
  AST_ILL_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_wr |-> !tlb_flush); // R14
  AST_TIMER_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= A_TMR0 && wr_addr <= A_TMR_LAST) |=> !illegal_wr && !tlb_flush); // R13
endmodule

// File: tb/csr_mask_unit_tb_top.sv
module csr_mask_unit_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [63:0] wr_data;
  logic [4:0]  rd_addr;
  logic [63:0] rd_data;
  logic        tlb_flush, illegal_wr, irq_ssip, irq_stip, irq_msip;

  int n_vec = 0;
  int n_bad = 0;

  logic [63:0] e_ms, e_mip, e_mie;
  logic [4:0]  e_ff;
  logic [2:0]  e_rm;
  logic [63:0] e_reg [8];
  logic        e_fl;

  localparam logic [63:0] FL_M = 64'h0000_0000_003F_0036;

  always #(CLK_P/2) clk = ~clk;

  csr_mask_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tlb_flush(tlb_flush), .illegal_wr(illegal_wr),
    .irq_ssip(irq_ssip), .irq_stip(irq_stip), .irq_msip(irq_msip)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic chk_rd(input string rq, input logic [4:0] a, input logic [63:0] exp);
    rd_addr = a;
    #1;
    chk(rq, rd_data, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // expected machine-status update (R3..R7)
  task automatic model_ms(input logic [63:0] v);
    logic [63:0] m;
    e_fl = |((v ^ e_ms) & FL_M);
    m = 64'h0001_3049;
    if (v[2:1] != 2'd2) m |= 64'h6;
    if (v[5:4] != 2'd2) m |= 64'h30;
    if (v[8:7] != 2'd2) m |= 64'h180;
    if (v[21:17] == 5'd0 || v[21:17] == 5'd9) m |= 64'h003E_0000;
    e_ms = (e_ms & ~m) | (v & m);
    e_ms[63] = (e_ms[13:12] == 2'b11) || (e_ms[15:14] == 2'b11);
  endtask

  task automatic ms_write(input string rq, input logic [63:0] v);
    model_ms(v);
    wr(5'd3, v);
    chk({rq, " flush"}, {63'd0, tlb_flush}, {63'd0, e_fl});
    chk_rd({rq, " mstatus"}, 5'd3, e_ms);
  endtask

  task automatic ss_write(input logic [63:0] d);
    logic [63:0] v;
    v = e_ms;
    v[0] = d[0]; v[3] = d[3]; v[5:4] = {1'b0, d[4]};
    v[13:12] = d[13:12]; v[16] = d[16];
    model_ms(v);
    wr(5'd4, d);
    chk("R8 R7 sstatus flush", {63'd0, tlb_flush}, {63'd0, e_fl});
    chk_rd("R8 sstatus view", 5'd4, e_ms & 64'h8000_0000_0001_F019);
    chk_rd("R8 R6 mstatus after sstatus", 5'd3, e_ms);
  endtask

  task automatic chk_irq(input string rq);
    chk({rq, " irq"}, {61'd0, irq_ssip, irq_stip, irq_msip},
        {61'd0, e_mip[1], e_mip[5], e_mip[3]});
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    rst_n = 1'b0;
    e_ms = 64'h6; e_mip = '0; e_mie = '0; e_ff = '0; e_rm = '0;
    for (int i = 0; i < 8; i++) e_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk_rd("R3 reset mstatus", 5'd3, 64'h6);
    for (int a = 0; a < 32; a++)
      if (a != 3) chk_rd("R12 R13 R14 reset read zero", 5'(a), 64'h0);
    chk("R7 R14 reset flags", {62'd0, tlb_flush, illegal_wr}, 64'h0);
    chk_irq("R11 reset");

    // privilege sweep: R4, R7
    for (int k = 0; k < 64; k++) begin
      d = (64'(k[5:4]) << 7) | (64'(k[3:2]) << 4) | (64'(k[1:0]) << 1);
      ms_write("R4 R7 priv", d);
    end
    @(negedge clk);
    chk("R7 flush single cycle", {63'd0, tlb_flush}, 64'h0);

    // VM sweep: R5, R7
    for (int v = 0; v < 32; v++) begin
      d = e_ms;
      d[21:17] = 5'(v);
      ms_write("R5 R7 vm", d);
    end

    // always-writable fields and read-only XS: R3, R6
    for (int k = 0; k < 128; k++) begin
      d = e_ms;
      d[0] = k[0]; d[3] = k[1]; d[6] = k[2]; d[16] = k[3];
      d[13:12] = k[5:4]; d[15:14] = {k[6], k[6]};
      ms_write("R3 R6 fields", d);
    end

    // floating-point views: R1, R2
    ms_write("R1 clear fs", e_ms & ~64'h3000);
    wr(5'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    e_ff = 5'h1F; e_ms[13:12] = 2'b11; e_ms[63] = 1'b1;
    chk("R1 no flush on fp", {63'd0, tlb_flush}, 64'h0);
    chk_rd("R1 fs dirty", 5'd3, e_ms);
    chk_rd("R2 fflags width", 5'd0, 64'h1F);
    ms_write("R1 clear fs again", e_ms & ~64'h3000);
    for (int k = 0; k < 16; k++) begin
      wr(5'd1, 64'(k) | 64'hF0);
      e_rm = 3'(k);
      e_ms[13:12] = 2'b11; e_ms[63] = 1'b1;
      chk_rd("R2 frm width", 5'd1, 64'(e_rm));
      chk_rd("R2 fflags kept", 5'd0, 64'(e_ff));
      chk_rd("R1 frm dirty", 5'd3, e_ms);
    end
    for (int k = 0; k < 256; k++) begin
      wr(5'd2, 64'(k) | 64'hABCD_0000_0000_0F00);
      e_ff = 5'(k); e_rm = 3'(k >> 5);
      chk_rd("R2 fcsr flags", 5'd0, 64'(e_ff));
      chk_rd("R2 fcsr mode", 5'd1, 64'(e_rm));
      chk_rd("R2 fcsr view", 5'd2, 64'(k));
    end
    chk_rd("R1 fcsr dirty", 5'd3, e_ms);

    // supervisor status: R8
    for (int k = 0; k < 256; k++) begin
      d = 64'h7FFE_0000_00FE_0FE6;
      d[0] = k[0]; d[3] = k[1]; d[4] = k[2]; d[12] = k[3];
      d[13] = k[4]; d[14] = k[5]; d[15] = k[6]; d[16] = k[7];
      ss_write(d);
    end

    // machine pending / enable: R9, R11
    for (int k = 0; k < 1024; k++) begin
      d = 64'(k) | 64'hFF00_0000_0000_F000;
      wr(5'd5, d);
      e_mip = d & 64'h2A;
      chk_rd("R9 mip mask", 5'd5, e_mip);
      chk_irq("R11 mirror");
      wr(5'd6, ~d);
      e_mie = ~d & 64'hAA;
      chk_rd("R9 mie mask", 5'd6, e_mie);
    end

    // supervisor pending / enable: R10
    for (int k = 0; k < 1024; k++) begin
      d = 64'(k);
      if (k[0]) begin
        wr(5'd5, 64'h2A);
        e_mip = 64'h2A;
      end
      wr(5'd7, d);
      e_mip = (e_mip & ~64'h2) | (d & 64'h2);
      chk_rd("R10 mip via sip", 5'd5, e_mip);
      chk_rd("R10 sip view", 5'd7, e_mip & 64'h22);
      chk_irq("R11 R10 sip");
      wr(5'd8, d);
      e_mie = (e_mie & ~64'h222) | (d & 64'h222);
      chk_rd("R10 mie via sie", 5'd6, e_mie);
      chk_rd("R10 sie view", 5'd8, e_mie & 64'h222);
    end

    // plain registers: R12
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 8; i++) begin
        d = (p == 0) ? 64'hFFFF_FFFF_FFFF_FFFF :
            (p == 1) ? 64'h0123_4567_89AB_CDEF ^ 64'(i) : 64'h8000_0000_0000_0FFF;
        wr(5'(9 + i), d);
        e_reg[i] = (i == 1) ? (d & ~64'h3) : (i == 2) ? (d & ~64'hFFF) : d;
      end
      for (int i = 0; i < 8; i++) chk_rd("R12 store", 5'(9 + i), e_reg[i]);
    end

    // timer addresses: R13
    for (int a = 17; a <= 20; a++) begin
      wr(5'(a), 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R13 no flag", {62'd0, tlb_flush, illegal_wr}, 64'h0);
      chk_rd("R13 read zero", 5'(a), 64'h0);
      chk_rd("R13 status kept", 5'd3, e_ms);
      chk_rd("R13 store kept", 5'd10, e_reg[1]);
    end

    // unimplemented addresses: R14
    for (int a = 21; a < 32; a++) begin
      wr(5'(a), 64'h5555_5555_5555_5555);
      chk("R14 flag", {63'd0, illegal_wr}, 64'h1);
      chk_rd("R14 read zero", 5'(a), 64'h0);
      chk_rd("R14 status kept", 5'd3, e_ms);
      chk_rd("R14 mip kept", 5'd5, e_mip);
      @(negedge clk);
      chk("R14 flag one cycle", {63'd0, illegal_wr}, 64'h0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule